// File: doc/BRIEF.md
# Character-Assembling I/O Word Buffer

This block couples a character-wide peripheral port to a word-wide memory port. Each device character is six data bits with one parity bit alongside. A configuration command opens a link and fixes its direction, the number of characters per word and the parity sense. In the input direction, incoming characters are parity-checked, packed into a word starting at the high-order end, and a loaded flag tells the memory side that a word is waiting. In the output direction, the memory side writes a word while the ready flag is high. The block then hands out one character per device request, high-order character first, each with a freshly generated parity bit.

The link can close in three ways. The device can signal end-of-record on input. Software can drop the link at once. Software can also ask for a graceful output close, which finishes the word in progress first. Word completion and record end are reported as single-cycle event pulses for an interrupt controller. Misuse is collected in one sticky error flag: a bad parity bit, a character that arrives while a full word is still unread, or a device request when no word is waiting.

Top module: `char_word_buffer`

## Requirements
- R1: After reset, connected, loaded, ready, err, evt_eow, evt_eor and dev_out_valid are all 0.
- R2: A cfg_valid pulse opens the link on the next clock edge: connected becomes 1 and err is cleared. cfg_dir selects the direction (0 = input, 1 = output). ready is 1 only in the output direction while no word is held.
- R3: cfg_cpw selects the characters per word: code 0 = 1 character up to code 3 = 4 characters. Character k of a word occupies bits [23-6k : 18-6k], so the first character lands in bits 23:18. loaded rises on the edge that accepts the last character. Unfilled positions read as zero on mem_rdata.
- R4: evt_eow pulses high for exactly one cycle when an input word is completed, and when the last character of an output word is sent.
- R5: cfg_even = 1 selects even parity and 0 selects odd parity: the six data bits plus the parity bit hold an even or odd number of ones. An input character with the wrong parity bit sets err and is still stored.
- R6: A character strobed while loaded is 1 is discarded: mem_rdata is unchanged and err is set.
- R7: dev_in_eor on an input link clears connected and pulses evt_eor. If one or more characters of an unfinished word are held, loaded rises with the remaining low-order positions at zero. With no characters held, loaded stays 0.
- R8: mem_rd while loaded clears loaded and the held word (mem_rdata reads 0). The next character then fills the first position again.
- R9: In the output direction, mem_wr while ready stores the word and drops ready. Each dev_out_req then yields dev_out_valid one cycle later, carrying the next character (high-order first) and its generated parity. ready returns once the last character is sent.
- R10: dev_out_req on an output link with no word held sets err and produces no dev_out_valid.
- R11: disc_now clears connected on the next edge without any evt_eor. After that, device strobes and requests are ignored: no load, no output and no error.
- R12: term_out on an output link blocks further mem_wr. The characters still held are sent. On the edge after the last one is sent, connected clears and evt_eor pulses once. With nothing held, this happens on the second edge after the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_valid | input | 1 | Open-link command pulse |
| cfg_dir | input | 1 | Direction for the command: 0 input, 1 output |
| cfg_cpw | input | 2 | Characters per word minus one |
| cfg_even | input | 1 | 1 even parity, 0 odd parity |
| disc_now | input | 1 | Drop the link at once |
| term_out | input | 1 | Close the output link after the held word drains |
| dev_in_strobe | input | 1 | Input character present this cycle |
| dev_in_data | input | 6 | Input character |
| dev_in_par | input | 1 | Input parity bit |
| dev_in_eor | input | 1 | End of record from the device |
| dev_out_req | input | 1 | Device asks for the next output character |
| dev_out_valid | output | 1 | Output character present this cycle |
| dev_out_data | output | 6 | Output character |
| dev_out_par | output | 1 | Generated parity of the output character |
| mem_wr | input | 1 | Memory writes a word for output |
| mem_wdata | input | 24 | Word to send |
| mem_rd | input | 1 | Memory takes the loaded input word |
| mem_rdata | output | 24 | Assembled input word |
| connected | output | 1 | Link open |
| loaded | output | 1 | Input word waiting for memory |
| ready | output | 1 | Output side can take a word |
| err | output | 1 | Sticky error flag |
| evt_eow | output | 1 | End-of-word event pulse |
| evt_eor | output | 1 | End-of-record / termination event pulse |

## Verification
The properties assume that every control and device input is a single-cycle pulse. They also assume that a configuration command never overlaps another command in a way the checks would need to arbitrate; the antecedents exclude cfg_valid explicitly. The overrun and word-stability checks further assume that the memory side only asserts mem_wr in the output direction. The stimulus drives each pulse for exactly one cycle from a falling edge. It never raises two commands together, and it never lets end-of-record coincide with a character strobe, so every run stays inside these assumptions.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
  typedef enum logic {
    DIR_IN  = 1'b0,
    DIR_OUT = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/cwb_parity.sv
// Parity bit that makes data plus parity carry an even (even_mode=1)
// or odd (even_mode=0) number of ones.
module cwb_parity #(
  parameter int CHAR_W = 6
) (
  input  logic [CHAR_W-1:0] data,
  input  logic              even_mode,
  output logic              par
);
  assign par = (^data) ^ ~even_mode;
endmodule

// File: rtl/cwb_link_ctrl.sv
// Link state: connection, direction, word length, parity sense,
// pending graceful termination, record-end event and the error flag.
module cwb_link_ctrl
  import cwb_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid,
  input  logic             cfg_dir,
  input  logic [CNT_W-1:0] cfg_cpw,
  input  logic             cfg_even,
  input  logic             disc_now,
  input  logic             term_out,
  input  logic             in_eor,
  input  logic             buf_full,
  input  logic             err_set,
  output logic             conn,
  output xfer_dir_e        dir,
  output logic [CNT_W-1:0] cpw,
  output logic             even,
  output logic             term_pend,
  output logic             evt_eor,
  output logic             err
);
  logic             conn_q, conn_n;
  xfer_dir_e        dir_q, dir_n;
  logic [CNT_W-1:0] cpw_q, cpw_n;
  logic             even_q, even_n;
  logic             term_q, term_n;
  logic             evt_q, evt_n;
  logic             err_q, err_n;

  always_comb begin
    conn_n = conn_q;
    dir_n  = dir_q;
    cpw_n  = cpw_q;
    even_n = even_q;
    term_n = term_q;
    err_n  = err_q;
    evt_n  = 1'b0;
    if (cfg_valid) begin
      conn_n = 1'b1;
      dir_n  = xfer_dir_e'(cfg_dir);
      cpw_n  = cfg_cpw;
      even_n = cfg_even;
      term_n = 1'b0;
      err_n  = 1'b0;
    end else begin
      if (err_set) err_n = 1'b1;
      if (disc_now) begin
        conn_n = 1'b0;
        term_n = 1'b0;
      end else if (conn_q && dir_q == DIR_IN && in_eor) begin
        conn_n = 1'b0;
        evt_n  = 1'b1;
      end else if (conn_q && dir_q == DIR_OUT && term_q && !buf_full) begin
        conn_n = 1'b0;
        term_n = 1'b0;
        evt_n  = 1'b1;
      end else if (conn_q && dir_q == DIR_OUT && term_out) begin
        term_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conn_q <= 1'b0;
      dir_q  <= DIR_IN;
      cpw_q  <= '0;
      even_q <= 1'b0;
      term_q <= 1'b0;
      evt_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      conn_q <= conn_n;
      dir_q  <= dir_n;
      cpw_q  <= cpw_n;
      even_q <= even_n;
      term_q <= term_n;
      evt_q  <= evt_n;
      err_q  <= err_n;
    end
  end

  assign conn      = conn_q;
  assign dir       = dir_q;
  assign cpw       = cpw_q;
  assign even      = even_q;
  assign term_pend = term_q;
  assign evt_eor   = evt_q;
  assign err       = err_q;
endmodule

// File: rtl/cwb_word_store.sv
// Word register with left-aligned character slots, slot counter and
// full flag, shared by both directions; registered device output.
module cwb_word_store
  import cwb_pkg::*;
#(
  parameter  int CHAR_W    = 6,
  parameter  int MAX_CHARS = 4,
  localparam int WORD_W    = CHAR_W * MAX_CHARS,
  localparam int CNT_W     = $clog2(MAX_CHARS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              conn,
  input  xfer_dir_e         dir,
  input  logic [CNT_W-1:0]  cpw,
  input  logic              term_pend,
  input  logic              in_stb,
  input  logic [CHAR_W-1:0] in_char,
  input  logic              in_eor,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  logic [WORD_W-1:0] mem_wdata,
  input  logic              out_req,
  input  logic              out_par_gen,
  output logic [WORD_W-1:0] word,
  output logic              full,
  output logic [CHAR_W-1:0] cur_char,
  output logic              in_take,
  output logic              in_over,
  output logic              out_under,
  output logic              out_valid,
  output logic [CHAR_W-1:0] out_data,
  output logic              out_par,
  output logic              evt_eow
);
  logic [WORD_W-1:0] word_q, word_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              full_q, full_n;
  logic              vld_q, vld_n;
  logic [CHAR_W-1:0] dat_q, dat_n;
  logic              par_q, par_n;
  logic              eow_q, eow_n;

  logic in_act, out_act, last, out_take, wr_ok, rd_ok;
  logic [CHAR_W-1:0] slot [MAX_CHARS];

  for (genvar g = 0; g < MAX_CHARS; g++) begin : g_slot
    assign slot[g] = word_q[WORD_W-1-g*CHAR_W -: CHAR_W];
  end
  assign cur_char = slot[cnt_q];

  assign in_act    = conn && dir == DIR_IN;
  assign out_act   = conn && dir == DIR_OUT;
  assign last      = cnt_q == cpw;
  assign in_take   = in_stb && in_act && !full_q;
  assign in_over   = in_stb && in_act && full_q;
  assign out_take  = out_req && out_act && full_q;
  assign out_under = out_req && out_act && !full_q;
  assign wr_ok     = mem_wr && out_act && !full_q && !term_pend;
  assign rd_ok     = mem_rd && dir == DIR_IN && full_q;

  always_comb begin
    word_n = word_q;
    cnt_n  = cnt_q;
    full_n = full_q;
    vld_n  = 1'b0;
    dat_n  = '0;
    par_n  = 1'b0;
    eow_n  = 1'b0;
    if (clr) begin
      word_n = '0;
      cnt_n  = '0;
      full_n = 1'b0;
    end else begin
      if (rd_ok) begin
        word_n = '0;
        cnt_n  = '0;
        full_n = 1'b0;
      end
      if (wr_ok) begin
        word_n = mem_wdata;
        cnt_n  = '0;
        full_n = 1'b1;
      end
      if (in_take) begin
        for (int i = 0; i < MAX_CHARS; i++) begin
          if (cnt_q == CNT_W'(i)) word_n[WORD_W-1-i*CHAR_W -: CHAR_W] = in_char;
        end
        if (last) begin
          full_n = 1'b1;
          cnt_n  = '0;
          eow_n  = 1'b1;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      // record end with a partial word: unused slots are already zero
      if (in_eor && in_act && !full_n && cnt_n != '0) full_n = 1'b1;
      if (out_take) begin
        vld_n = 1'b1;
        dat_n = cur_char;
        par_n = out_par_gen;
        if (last) begin
          full_n = 1'b0;
          cnt_n  = '0;
          eow_n  = 1'b1;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt_q  <= '0;
      full_q <= 1'b0;
      vld_q  <= 1'b0;
      dat_q  <= '0;
      par_q  <= 1'b0;
      eow_q  <= 1'b0;
    end else begin
      word_q <= word_n;
      cnt_q  <= cnt_n;
      full_q <= full_n;
      vld_q  <= vld_n;
      dat_q  <= dat_n;
      par_q  <= par_n;
      eow_q  <= eow_n;
    end
  end

  assign word      = word_q;
  assign full      = full_q;
  assign out_valid = vld_q;
  assign out_data  = dat_q;
  assign out_par   = par_q;
  assign evt_eow   = eow_q;
endmodule

// File: rtl/char_word_buffer.sv
module char_word_buffer
  import cwb_pkg::*;
#(
  parameter  int CHAR_W    = 6,
  parameter  int MAX_CHARS = 4,
  localparam int WORD_W    = CHAR_W * MAX_CHARS,
  localparam int CNT_W     = $clog2(MAX_CHARS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic              cfg_dir,
  input  logic [CNT_W-1:0]  cfg_cpw,
  input  logic              cfg_even,
  input  logic              disc_now,
  input  logic              term_out,
  input  logic              dev_in_strobe,
  input  logic [CHAR_W-1:0] dev_in_data,
  input  logic              dev_in_par,
  input  logic              dev_in_eor,
  input  logic              dev_out_req,
  output logic              dev_out_valid,
  output logic [CHAR_W-1:0] dev_out_data,
  output logic              dev_out_par,
  input  logic              mem_wr,
  input  logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_rd,
  output logic [WORD_W-1:0] mem_rdata,
  output logic              connected,
  output logic              loaded,
  output logic              ready,
  output logic              err,
  output logic              evt_eow,
  output logic              evt_eor
);
  logic [1:0]        rst_pipe;
  logic              rst_int_n;
  logic              conn, even, term_pend, full;
  xfer_dir_e         dir;
  logic [CNT_W-1:0]  cpw;
  logic [CHAR_W-1:0] cur_char;
  logic              in_take, in_over, out_under;
  logic              exp_par, gen_par, par_err;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  cwb_parity #(.CHAR_W(CHAR_W)) u_par_chk (
    .data(dev_in_data), .even_mode(even), .par(exp_par)
  );
  cwb_parity #(.CHAR_W(CHAR_W)) u_par_gen (
    .data(cur_char), .even_mode(even), .par(gen_par)
  );

  assign par_err = in_take && (dev_in_par != exp_par);

  cwb_link_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cfg_valid (cfg_valid),
    .cfg_dir   (cfg_dir),
    .cfg_cpw   (cfg_cpw),
    .cfg_even  (cfg_even),
    .disc_now  (disc_now),
    .term_out  (term_out),
    .in_eor    (dev_in_eor),
    .buf_full  (full),
    .err_set   (par_err | in_over | out_under),
    .conn      (conn),
    .dir       (dir),
    .cpw       (cpw),
    .even      (even),
    .term_pend (term_pend),
    .evt_eor   (evt_eor),
    .err       (err)
  );

  cwb_word_store #(.CHAR_W(CHAR_W), .MAX_CHARS(MAX_CHARS)) u_store (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .clr         (cfg_valid),
    .conn        (conn),
    .dir         (dir),
    .cpw         (cpw),
    .term_pend   (term_pend),
    .in_stb      (dev_in_strobe),
    .in_char     (dev_in_data),
    .in_eor      (dev_in_eor),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .mem_wdata   (mem_wdata),
    .out_req     (dev_out_req),
    .out_par_gen (gen_par),
    .word        (mem_rdata),
    .full        (full),
    .cur_char    (cur_char),
    .in_take     (in_take),
    .in_over     (in_over),
    .out_under   (out_under),
    .out_valid   (dev_out_valid),
    .out_data    (dev_out_data),
    .out_par     (dev_out_par),
    .evt_eow     (evt_eow)
  );

  assign connected = conn;
  assign loaded    = (dir == DIR_IN) && full;
  assign ready     = conn && (dir == DIR_OUT) && !full && !term_pend;
endmodule

// File: rtl/cwb_checker.sv
module cwb_checker #(
  parameter int WORD_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_valid,
  input logic              disc_now,
  input logic              dev_in_strobe,
  input logic              dev_out_req,
  input logic              dev_out_valid,
  input logic              mem_rd,
  input logic [WORD_W-1:0] mem_rdata,
  input logic              connected,
  input logic              loaded,
  input logic              ready,
  input logic              err,
  input logic              evt_eow,
  input logic              evt_eor
);
  assert_valid_after_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dev_out_valid |-> $past(dev_out_req));

  assert_underrun_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_out_req && ready && !cfg_valid) |=> err);

  assert_overrun_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_in_strobe && loaded && connected && !cfg_valid) |=> err);

  assert_disc_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (disc_now && !cfg_valid) |=> (!connected && !evt_eor));

  assert_eor_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_eor |-> !connected);

  assert_word_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && !mem_rd && !cfg_valid) |=> (loaded && $stable(mem_rdata)));

  assert_ready_loaded_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && loaded));

  assert_eow_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_eow |=> !evt_eow);
endmodule

bind char_word_buffer cwb_checker #(.WORD_W(WORD_W)) u_cwb_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_valid     (cfg_valid),
  .disc_now      (disc_now),
  .dev_in_strobe (dev_in_strobe),
  .dev_out_req   (dev_out_req),
  .dev_out_valid (dev_out_valid),
  .mem_rd        (mem_rd),
  .mem_rdata     (mem_rdata),
  .connected     (connected),
  .loaded        (loaded),
  .ready         (ready),
  .err           (err),
  .evt_eow       (evt_eow),
  .evt_eor       (evt_eor)
);

// File: tb/tb_char_word_buffer.sv
`timescale 1ns/1ps
module tb_char_word_buffer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_valid, cfg_dir, cfg_even;
  logic [1:0]  cfg_cpw;
  logic        disc_now, term_out;
  logic        dev_in_strobe, dev_in_par, dev_in_eor, dev_out_req;
  logic [5:0]  dev_in_data, dev_out_data;
  logic        dev_out_valid, dev_out_par;
  logic        mem_wr, mem_rd;
  logic [23:0] mem_wdata, mem_rdata;
  logic        connected, loaded, ready, err, evt_eow, evt_eor;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  char_word_buffer dut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_dir(cfg_dir),
    .cfg_cpw(cfg_cpw), .cfg_even(cfg_even), .disc_now(disc_now),
    .term_out(term_out), .dev_in_strobe(dev_in_strobe),
    .dev_in_data(dev_in_data), .dev_in_par(dev_in_par),
    .dev_in_eor(dev_in_eor), .dev_out_req(dev_out_req),
    .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data),
    .dev_out_par(dev_out_par), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rd(mem_rd), .mem_rdata(mem_rdata), .connected(connected),
    .loaded(loaded), .ready(ready), .err(err), .evt_eow(evt_eow),
    .evt_eor(evt_eor)
  );

  // {dir, cpw code, even, word}; octal words show one character per digit pair
  localparam logic [27:0] VECS [8] = '{
    {1'b0, 2'd3, 1'b0, 24'o01020304},
    {1'b0, 2'd2, 1'b1, 24'o77105500},
    {1'b0, 2'd1, 1'b0, 24'o12340000},
    {1'b0, 2'd0, 1'b1, 24'o63000000},
    {1'b1, 2'd3, 1'b0, 24'o01020304},
    {1'b1, 2'd2, 1'b1, 24'o77105512},
    {1'b1, 2'd1, 1'b1, 24'o12345670},
    {1'b1, 2'd0, 1'b0, 24'o40000077}
  };

  function automatic logic par_of(input logic [5:0] ch, input logic ev);
    return ev ? (^ch) : ~(^ch);
  endfunction

  function automatic logic [5:0] slot_of(input logic [23:0] w, input int k);
    return w[23-6*k -: 6];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic connect(input logic d, input logic [1:0] c, input logic e);
    cfg_valid = 1'b1; cfg_dir = d; cfg_cpw = c; cfg_even = e;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic send_char(input logic [5:0] ch, input logic p);
    dev_in_strobe = 1'b1; dev_in_data = ch; dev_in_par = p;
    @(negedge clk);
    dev_in_strobe = 1'b0;
  endtask

  task automatic pulse_req();
    dev_out_req = 1'b1; @(negedge clk); dev_out_req = 1'b0;
  endtask
  task automatic pulse_rd();
    mem_rd = 1'b1; @(negedge clk); mem_rd = 1'b0;
  endtask
  task automatic pulse_wr(input logic [23:0] w);
    mem_wr = 1'b1; mem_wdata = w; @(negedge clk); mem_wr = 1'b0;
  endtask
  task automatic pulse_eor();
    dev_in_eor = 1'b1; @(negedge clk); dev_in_eor = 1'b0;
  endtask
  task automatic pulse_disc();
    disc_now = 1'b1; @(negedge clk); disc_now = 1'b0;
  endtask
  task automatic pulse_term();
    term_out = 1'b1; @(negedge clk); term_out = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_valid = 0; cfg_dir = 0; cfg_cpw = 0; cfg_even = 0;
    disc_now = 0; term_out = 0; dev_in_strobe = 0; dev_in_data = 0;
    dev_in_par = 0; dev_in_eor = 0; dev_out_req = 0;
    mem_wr = 0; mem_rd = 0; mem_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 connected", connected, 0);
    chk("R1 loaded", loaded, 0);
    chk("R1 ready", ready, 0);
    chk("R1 err", err, 0);
    chk("R1 evt_eow", evt_eow, 0);
    chk("R1 evt_eor", evt_eor, 0);
    chk("R1 dev_out_valid", dev_out_valid, 0);

    // vector table: R2 R3 R4 R5 R8 R9
    for (int v = 0; v < 8; v++) begin
      logic        d, e;
      logic [1:0]  c;
      logic [23:0] w;
      d = VECS[v][27]; c = VECS[v][26:25]; e = VECS[v][24]; w = VECS[v][23:0];
      connect(d, c, e);
      chk("R2 connected", connected, 1);
      if (!d) begin
        chk("R2 ready in input", ready, 0);
        for (int i = 0; i <= int'(c); i++) begin
          if (i > 0) chk("R3 loaded early", loaded, 0);
          send_char(slot_of(w, i), par_of(slot_of(w, i), e));
        end
        chk("R3 loaded", loaded, 1);
        chk("R3 mem_rdata", mem_rdata, w);
        chk("R4 evt_eow in", evt_eow, 1);
        chk("R5 err good parity", err, 0);
        pulse_rd();
        chk("R8 loaded cleared", loaded, 0);
        chk("R8 word cleared", mem_rdata, 0);
      end else begin
        chk("R2 ready in output", ready, 1);
        pulse_wr(w);
        chk("R9 ready busy", ready, 0);
        for (int i = 0; i <= int'(c); i++) begin
          pulse_req();
          chk("R9 dev_out_valid", dev_out_valid, 1);
          chk("R9 dev_out_data", dev_out_data, slot_of(w, i));
          chk("R5 dev_out_par", dev_out_par, par_of(slot_of(w, i), e));
          chk("R4 evt_eow out", evt_eow, (i == int'(c)) ? 1 : 0);
        end
        chk("R9 ready again", ready, 1);
        chk("R10 no underrun", err, 0);
      end
      pulse_disc();
    end

    // R5 parity error, character kept; reconfigure clears err (R2)
    connect(1'b0, 2'd0, 1'b0);
    send_char(6'o25, ~par_of(6'o25, 1'b0));
    chk("R5 err bad parity", err, 1);
    chk("R5 loaded", loaded, 1);
    chk("R5 stored", mem_rdata, 24'o25000000);
    connect(1'b0, 2'd0, 1'b1);
    chk("R2 err cleared", err, 0);

    // R6 overrun, then R8 refill from the first position
    send_char(6'o41, par_of(6'o41, 1'b1));
    send_char(6'o17, par_of(6'o17, 1'b1));
    chk("R6 err", err, 1);
    chk("R6 loaded", loaded, 1);
    chk("R6 word kept", mem_rdata, 24'o41000000);
    pulse_rd();
    send_char(6'o17, par_of(6'o17, 1'b1));
    chk("R8 refill", mem_rdata, 24'o17000000);
    chk("R8 refill eow", evt_eow, 1);
    pulse_disc();

    // R7 record end with a partial word
    connect(1'b0, 2'd3, 1'b0);
    send_char(6'o11, par_of(6'o11, 1'b0));
    send_char(6'o22, par_of(6'o22, 1'b0));
    pulse_eor();
    chk("R7 loaded padded", loaded, 1);
    chk("R7 padded word", mem_rdata, 24'o11220000);
    chk("R7 evt_eor", evt_eor, 1);
    chk("R7 no eow", evt_eow, 0);
    chk("R7 disconnected", connected, 0);
    @(negedge clk);
    chk("R7 evt_eor one cycle", evt_eor, 0);
    // R7 record end with nothing held
    connect(1'b0, 2'd3, 1'b0);
    pulse_eor();
    chk("R7 empty not loaded", loaded, 0);
    chk("R7 empty evt_eor", evt_eor, 1);
    chk("R7 empty disconnected", connected, 0);

    // R10 underrun
    connect(1'b1, 2'd1, 1'b0);
    pulse_req();
    chk("R10 err", err, 1);
    chk("R10 no valid", dev_out_valid, 0);
    pulse_disc();

    // R11 immediate disconnect, input then output
    connect(1'b0, 2'd0, 1'b0);
    pulse_disc();
    chk("R11 disconnected", connected, 0);
    chk("R11 no event", evt_eor, 0);
    send_char(6'o33, par_of(6'o33, 1'b0));
    chk("R11 strobe ignored", loaded, 0);
    chk("R11 no err in", err, 0);
    connect(1'b1, 2'd0, 1'b0);
    pulse_wr(24'o55000000);
    pulse_disc();
    pulse_req();
    chk("R11 req ignored", dev_out_valid, 0);
    chk("R11 no err out", err, 0);
    chk("R11 ready low", ready, 0);

    // R12 graceful termination with a held word
    connect(1'b1, 2'd1, 1'b1);
    pulse_wr(24'o12345670);
    pulse_term();
    chk("R12 still connected", connected, 1);
    chk("R12 ready blocked", ready, 0);
    pulse_req();
    chk("R12 first char", dev_out_data, 6'o12);
    pulse_req();
    chk("R12 last char", dev_out_data, 6'o34);
    chk("R12 eow", evt_eow, 1);
    chk("R12 connected during drain", connected, 1);
    @(negedge clk);
    chk("R12 evt_eor", evt_eor, 1);
    chk("R12 disconnected", connected, 0);
    @(negedge clk);
    chk("R12 evt_eor one cycle", evt_eor, 0);
    // R12 termination with nothing held
    connect(1'b1, 2'd0, 1'b0);
    pulse_term();
    chk("R12 empty first edge", connected, 1);
    @(negedge clk);
    chk("R12 empty disconnected", connected, 0);
    chk("R12 empty evt_eor", evt_eor, 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule